// File: doc/BRIEF.md
# Serial Audio Clock Ratio Generator

This block produces the bit clock and the left/right word-select clock of a serial audio link from the codec master clock. The master clock also clocks the block. Two ratios set the frame: the number of master clock cycles in one frame (256, 384, 512 or 768) and the number of bit clocks in one frame (16, 24, 32 or 48). When the first ratio is not an integer multiple of the second, the bit clock edges are spread by a phase accumulator. A frame still lasts exactly the programmed number of master clock cycles and still holds exactly the programmed number of bit clocks.

In master mode the block drives both serial clocks and asserts their output enables. In slave mode the block does not drive the clocks. It brings externally supplied bit and word-select clocks into the master clock domain through a synchronizer and passes them on. In both modes a serializer gets two single-cycle strobes: one on each bit clock falling edge and one at each frame start. A separate register holds the direction of the codec master clock pin. Selecting master mode makes that pin an output.

New ratio requests wait in a pending register and take effect only at a frame boundary, so no frame is ever cut short.

Top module: `audio_clkgen`

## Requirements
- R1: In master mode, the frame (the interval between frame strobes) lasts F master clock cycles. F is the requested frame ratio when that ratio is 256, 384, 512 or 768. Any other requested value gives F = 256.
- R2: In master mode, each frame contains exactly B bit clock falling edges, where B is the active bit ratio (16, 24, 32 or 48). `bit_fall_stb` is high for one cycle in the cycle in which `bclk_out` has just gone from 1 to 0.
- R3: A request for a bit ratio other than 16, 24, 32 or 48 is ignored. The bit ratio accepted before it stays in effect.
- R4: When F is a multiple of B, every bit clock period in master mode lasts exactly F/B master clock cycles.
- R5: In master mode, `ws_out` is 0 for the first F/2 cycles of a frame and 1 for the last F/2 cycles. It changes only in a cycle that carries a bit clock falling strobe.
- R6: A ratio request written during a frame does not change that frame. It takes effect from the next frame boundary.
- R7: In master mode, `frame_stb` is a single-cycle strobe at each frame start. It coincides with `bit_fall_stb`, and `ws_out` is 0 in that cycle.
- R8: In slave mode, `bclk_out` and `ws_out` follow `ext_bclk` and `ext_ws` two master clock cycles after the input changes (default synchronizer depth). `bit_fall_stb` and `frame_stb` mark the falling edges of the synchronized bit clock and word-select. `bclk_oe` and `ws_oe` are 0.
- R9: A configuration write that selects master mode sets `mclk_oe` to 1 at the next edge. A write to the direction control sets `mclk_oe` to the inverse of `dir_is_input`, and in the same cycle it wins over the write that selects master mode. `bclk_oe` and `ws_oe` are 1 in master mode.
- R10: After reset the block is in slave mode. All clock outputs, strobes and enables are 0, `mclk_oe` is 0, and the ratios are 256 and 32.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Codec master clock; all logic runs on it |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_frame_ratio | input | FR_W | Requested master clocks per frame (numeric) |
| cfg_bit_ratio | input | BR_W | Requested bit clocks per frame (numeric) |
| cfg_master | input | 1 | 1 selects master mode on a configuration write |
| dir_wr | input | 1 | Master clock pin direction write strobe |
| dir_is_input | input | 1 | 1 makes the master clock pin an input |
| ext_bclk | input | 1 | External bit clock (slave mode) |
| ext_ws | input | 1 | External word-select (slave mode) |
| bclk_out | output | 1 | Bit clock |
| ws_out | output | 1 | Word-select, 0 = left channel |
| bclk_oe | output | 1 | Bit clock pin drive enable |
| ws_oe | output | 1 | Word-select pin drive enable |
| mclk_oe | output | 1 | Master clock pin drive enable |
| bit_fall_stb | output | 1 | One cycle per bit clock falling edge |
| frame_stb | output | 1 | One cycle per frame start |

## Verification
A corrupted phase accumulator or half-period counter shows up within a single frame. The frame length measured between frame strobes, the count of falling strobes, or the length of the word-select high phase then differs from the arithmetic value, at most F cycles after the fault. A wrong pending or active ratio register shows up at the first frame boundary after a write, because the next frame has the wrong length. The sweep measures every pair of supported ratios, including the non-integer divisions, and checks the slave path edge by edge with cycle-exact latency.

// File: rtl/audio_clkgen_pkg.sv
package audio_clkgen_pkg;

    typedef enum logic [1:0] {
        FR_256 = 2'd0,
        FR_384 = 2'd1,
        FR_512 = 2'd2,
        FR_768 = 2'd3
    } fr_sel_e;

    typedef enum logic [1:0] {
        BR_16 = 2'd0,
        BR_24 = 2'd1,
        BR_32 = 2'd2,
        BR_48 = 2'd3
    } br_sel_e;

    typedef struct packed {
        fr_sel_e pend_fr;
        br_sel_e pend_br;
        fr_sel_e act_fr;
        br_sel_e act_br;
        logic    master;
        logic    mclk_out;
    } cfg_state_t;

    // Unsupported frame ratios map to the 256 setting.
    function automatic fr_sel_e fr_decode(input int unsigned v);
        case (v)
            384:     return FR_384;
            512:     return FR_512;
            768:     return FR_768;
            default: return FR_256;
        endcase
    endfunction

    function automatic logic br_valid(input int unsigned v);
        return (v == 16) || (v == 24) || (v == 32) || (v == 48);
    endfunction

    function automatic br_sel_e br_decode(input int unsigned v);
        case (v)
            24:      return BR_24;
            32:      return BR_32;
            48:      return BR_48;
            default: return BR_16;
        endcase
    endfunction

    function automatic int unsigned fr_value(input fr_sel_e s);
        case (s)
            FR_384:  return 384;
            FR_512:  return 512;
            FR_768:  return 768;
            default: return 256;
        endcase
    endfunction

    function automatic int unsigned br_value(input br_sel_e s);
        case (s)
            BR_24:   return 24;
            BR_32:   return 32;
            BR_48:   return 48;
            default: return 16;
        endcase
    endfunction

endpackage

// File: rtl/audio_ratio_cfg.sv
module audio_ratio_cfg
    import audio_clkgen_pkg::*;
#(
    parameter int FR_W = 10,
    parameter int BR_W = 6
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [FR_W-1:0] req_frame,
    input  logic [BR_W-1:0] req_bit,
    input  logic            req_master,
    input  logic            dir_wr,
    input  logic            dir_is_input,
    input  logic            frame_edge,
    output fr_sel_e         act_fr,
    output br_sel_e         act_br,
    output logic            master_mode,
    output logic            mclk_out_en
);

    cfg_state_t state_d, state_q;

    always_comb begin
        state_d = state_q;
        if (cfg_wr) begin
            state_d.pend_fr = fr_decode(int'(req_frame));
            if (br_valid(int'(req_bit))) begin
                state_d.pend_br = br_decode(int'(req_bit));
            end
            state_d.master = req_master;
            if (req_master) begin
                state_d.mclk_out = 1'b1;
            end
        end
        if (dir_wr) begin
            state_d.mclk_out = ~dir_is_input;
        end
        // Promote the pending ratios only when the frame wraps.
        if (frame_edge) begin
            state_d.act_fr = state_q.pend_fr;
            state_d.act_br = state_q.pend_br;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{pend_fr: FR_256, pend_br: BR_32,
                         act_fr: FR_256, act_br: BR_32,
                         master: 1'b0, mclk_out: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    assign act_fr      = state_q.act_fr;
    assign act_br      = state_q.act_br;
    assign master_mode = state_q.master;
    assign mclk_out_en = state_q.mclk_out;

endmodule

// File: rtl/audio_bclk_gen.sv
module audio_bclk_gen
    import audio_clkgen_pkg::*;
#(
    parameter int FR_W = 10,
    parameter int BR_W = 6
) (
    input  logic    clk,
    input  logic    rst_n,
    input  fr_sel_e act_fr,
    input  br_sel_e act_br,
    output logic    wrap,
    output logic    bclk,
    output logic    ws,
    output logic    fall_stb,
    output logic    frame_stb
);

    localparam int ACC_W = FR_W + 1;
    localparam int CNT_W = BR_W + 1;

    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [CNT_W-1:0] half;
        logic             bclk;
        logic             ws;
        logic             fall;
        logic             frame;
    } gen_state_t;

    gen_state_t state_d, state_q;

    logic [ACC_W-1:0] frame_len;
    logic [ACC_W-1:0] step;
    logic [ACC_W-1:0] sum;
    logic [CNT_W-1:0] half_last;
    logic [CNT_W-1:0] half_mid;
    logic             toggle;

    always_comb begin
        frame_len = ACC_W'(fr_value(act_fr));
        step      = ACC_W'(2 * br_value(act_br));
        half_last = CNT_W'(2 * br_value(act_br) - 1);
        half_mid  = CNT_W'(br_value(act_br) - 1);
        sum       = state_q.acc + step;
        toggle    = (sum >= frame_len);
        wrap      = toggle && (state_q.half == half_last);

        state_d       = state_q;
        state_d.fall  = 1'b0;
        state_d.frame = 1'b0;
        if (toggle) begin
            state_d.acc  = sum - frame_len;
            state_d.bclk = ~state_q.bclk;
            state_d.fall = state_q.bclk;
            if (wrap) begin
                state_d.acc   = '0;
                state_d.half  = '0;
                state_d.ws    = 1'b0;
                state_d.frame = 1'b1;
            end else begin
                state_d.half = state_q.half + 1'b1;
                if (state_q.half == half_mid) begin
                    state_d.ws = 1'b1;
                end
            end
        end else begin
            state_d.acc = sum;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bclk      = state_q.bclk;
    assign ws        = state_q.ws;
    assign fall_stb  = state_q.fall;
    assign frame_stb = state_q.frame;

endmodule

// File: rtl/audio_ext_clk_sync.sv
module audio_ext_clk_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic ext_bclk,
    input  logic ext_ws,
    output logic bclk,
    output logic ws,
    output logic fall_stb,
    output logic frame_stb
);

    typedef struct packed {
        logic [STAGES-1:0] bsync;
        logic [STAGES-1:0] wsync;
        logic              bprev;
        logic              wprev;
    } sync_state_t;

    sync_state_t state_d, state_q;

    always_comb begin
        state_d       = state_q;
        state_d.bsync = {state_q.bsync[STAGES-2:0], ext_bclk};
        state_d.wsync = {state_q.wsync[STAGES-2:0], ext_ws};
        state_d.bprev = state_q.bsync[STAGES-1];
        state_d.wprev = state_q.wsync[STAGES-1];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign bclk      = state_q.bsync[STAGES-1];
    assign ws        = state_q.wsync[STAGES-1];
    assign fall_stb  = state_q.bprev & ~state_q.bsync[STAGES-1];
    assign frame_stb = state_q.wprev & ~state_q.wsync[STAGES-1];

endmodule

// File: rtl/audio_clkgen.sv
module audio_clkgen
    import audio_clkgen_pkg::*;
#(
    parameter int FR_W        = 10,
    parameter int BR_W        = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_wr,
    input  logic [FR_W-1:0] cfg_frame_ratio,
    input  logic [BR_W-1:0] cfg_bit_ratio,
    input  logic            cfg_master,
    input  logic            dir_wr,
    input  logic            dir_is_input,
    input  logic            ext_bclk,
    input  logic            ext_ws,
    output logic            bclk_out,
    output logic            ws_out,
    output logic            bclk_oe,
    output logic            ws_oe,
    output logic            mclk_oe,
    output logic            bit_fall_stb,
    output logic            frame_stb
);

    fr_sel_e act_fr;
    br_sel_e act_br;
    logic    master_mode;
    logic    gen_wrap;
    logic    gen_bclk, gen_ws, gen_fall, gen_frame;
    logic    ext_s_bclk, ext_s_ws, ext_s_fall, ext_s_frame;

    audio_ratio_cfg #(.FR_W(FR_W), .BR_W(BR_W)) u_cfg (
        .clk         (clk),
        .rst_n       (rst_n),
        .cfg_wr      (cfg_wr),
        .req_frame   (cfg_frame_ratio),
        .req_bit     (cfg_bit_ratio),
        .req_master  (cfg_master),
        .dir_wr      (dir_wr),
        .dir_is_input(dir_is_input),
        .frame_edge  (gen_wrap),
        .act_fr      (act_fr),
        .act_br      (act_br),
        .master_mode (master_mode),
        .mclk_out_en (mclk_oe)
    );

    audio_bclk_gen #(.FR_W(FR_W), .BR_W(BR_W)) u_gen (
        .clk      (clk),
        .rst_n    (rst_n),
        .act_fr   (act_fr),
        .act_br   (act_br),
        .wrap     (gen_wrap),
        .bclk     (gen_bclk),
        .ws       (gen_ws),
        .fall_stb (gen_fall),
        .frame_stb(gen_frame)
    );

    audio_ext_clk_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .ext_bclk (ext_bclk),
        .ext_ws   (ext_ws),
        .bclk     (ext_s_bclk),
        .ws       (ext_s_ws),
        .fall_stb (ext_s_fall),
        .frame_stb(ext_s_frame)
    );

    always_comb begin
        if (master_mode) begin
            bclk_out     = gen_bclk;
            ws_out       = gen_ws;
            bit_fall_stb = gen_fall;
            frame_stb    = gen_frame;
        end else begin
            bclk_out     = ext_s_bclk;
            ws_out       = ext_s_ws;
            bit_fall_stb = ext_s_fall;
            frame_stb    = ext_s_frame;
        end
    end

    assign bclk_oe = master_mode;
    assign ws_oe   = master_mode;

endmodule

// File: rtl/audio_clkgen_checker.sv
module audio_clkgen_checker
    import audio_clkgen_pkg::*;
(
    input logic    clk,
    input logic    rst_n,
    input logic    master_mode,
    input logic    bclk_out,
    input logic    ws_out,
    input logic    bit_fall_stb,
    input logic    frame_stb,
    input logic    gen_wrap,
    input fr_sel_e act_fr,
    input br_sel_e act_br,
    input logic    mclk_oe,
    input logic    cfg_wr,
    input logic    cfg_master,
    input logic    dir_wr
);

    assert_frame_on_fall_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && frame_stb) |-> (bit_fall_stb && !ws_out));

    assert_fall_is_edge_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && $past(master_mode) && bit_fall_stb) |-> (!bclk_out && $past(bclk_out)));

    assert_ws_moves_on_fall_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (master_mode && $past(master_mode) && !$stable(ws_out)) |-> bit_fall_stb);

    assert_ratio_at_boundary_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !gen_wrap |=> ($stable(act_fr) && $stable(act_br)));

    assert_master_drives_mclk_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_master && !dir_wr) |=> mclk_oe);

endmodule

bind audio_clkgen audio_clkgen_checker u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .master_mode (master_mode),
    .bclk_out    (bclk_out),
    .ws_out      (ws_out),
    .bit_fall_stb(bit_fall_stb),
    .frame_stb   (frame_stb),
    .gen_wrap    (gen_wrap),
    .act_fr      (act_fr),
    .act_br      (act_br),
    .mclk_oe     (mclk_oe),
    .cfg_wr      (cfg_wr),
    .cfg_master  (cfg_master),
    .dir_wr      (dir_wr)
);

// File: tb/audio_clkgen_test.sv
module audio_clkgen_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cfg_wr = 1'b0;
    logic [9:0] cfg_frame_ratio = '0;
    logic [5:0] cfg_bit_ratio = '0;
    logic       cfg_master = 1'b0;
    logic       dir_wr = 1'b0;
    logic       dir_is_input = 1'b0;
    logic       ext_bclk = 1'b0;
    logic       ext_ws = 1'b0;
    logic       bclk_out, ws_out, bclk_oe, ws_oe, mclk_oe, bit_fall_stb, frame_stb;

    int checks = 0;
    int errors = 0;
    int m_len, m_falls, m_wshi, m_badgap;

    always #2 clk = ~clk;

    audio_clkgen uut (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr),
        .cfg_frame_ratio(cfg_frame_ratio), .cfg_bit_ratio(cfg_bit_ratio),
        .cfg_master(cfg_master), .dir_wr(dir_wr), .dir_is_input(dir_is_input),
        .ext_bclk(ext_bclk), .ext_ws(ext_ws), .bclk_out(bclk_out), .ws_out(ws_out),
        .bclk_oe(bclk_oe), .ws_oe(ws_oe), .mclk_oe(mclk_oe),
        .bit_fall_stb(bit_fall_stb), .frame_stb(frame_stb)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic write_cfg(input int fr, input int br, input bit master);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_frame_ratio = 10'(fr); cfg_bit_ratio = 6'(br); cfg_master = master;
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    task automatic wait_frame();
        @(negedge clk);
        while (!frame_stb) @(negedge clk);
    endtask

    // Measures one frame starting at the next frame strobe.
    task automatic measure(input int exp_gap);
        int last;
        wait_frame();
        m_len = 0; m_falls = 0; m_wshi = 0; m_badgap = 0; last = 0;
        do begin
            @(negedge clk);
            m_len++;
            if (ws_out) m_wshi++;
            if (bit_fall_stb) begin
                m_falls++;
                if (exp_gap != 0 && (m_len - last) != exp_gap) m_badgap++;
                last = m_len;
            end
        end while (!frame_stb && m_len < 2000);
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog all requirements actual=%0d expected=%0d", 190000, 0);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int frs[4];
        int brs[4];
        frs = '{256, 384, 512, 768};
        brs = '{16, 24, 32, 48};

        repeat (3) @(negedge clk);
        // R10: state during and after reset
        check(bclk_out == 0 && ws_out == 0, "R10 clocks idle in reset", {bclk_out, ws_out}, 0);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
        check(bclk_oe == 0 && ws_oe == 0, "R10 enables low after reset", {bclk_oe, ws_oe}, 0);
        check(mclk_oe == 0, "R10 mclk_oe low after reset", mclk_oe, 0);
        check(bit_fall_stb == 0 && frame_stb == 0, "R10 strobes low", {bit_fall_stb, frame_stb}, 0);

        // R9: master selection makes the master clock pin an output
        write_cfg(256, 32, 1'b1);
        check(mclk_oe == 1, "R9 master sets mclk_oe", mclk_oe, 1);
        check(bclk_oe == 1 && ws_oe == 1, "R9 enables in master", {bclk_oe, ws_oe}, 3);
        measure(8);
        check(m_len == 256, "R10 default frame length", m_len, 256);

        // R1 R2 R4 R5: sweep every supported pair
        foreach (frs[i]) begin
            foreach (brs[j]) begin
                int f, b, g;
                f = frs[i]; b = brs[j];
                g = (f % b == 0) ? f / b : 0;
                write_cfg(f, b, 1'b1);
                wait_frame();
                measure(g);
                check(m_len == f, $sformatf("R1 frame length %0d/%0d", f, b), m_len, f);
                check(m_falls == b, $sformatf("R2 falls per frame %0d/%0d", f, b), m_falls, b);
                check(m_wshi == f / 2, $sformatf("R5 ws high cycles %0d/%0d", f, b), m_wshi, f / 2);
                if (g != 0)
                    check(m_badgap == 0, $sformatf("R4 uniform period %0d/%0d", f, b), m_badgap, 0);
            end
        end

        // R3 and R1 fallback: 300 -> 256, bit 20 keeps 48
        write_cfg(300, 20, 1'b1);
        wait_frame();
        measure(0);
        check(m_len == 256, "R1 unsupported frame falls back", m_len, 256);
        check(m_falls == 48, "R3 unsupported bit ratio ignored", m_falls, 48);
        write_cfg(384, 63, 1'b1);
        wait_frame();
        measure(8);
        check(m_len == 384 && m_falls == 48, "R3 bit ratio still 48", m_falls, 48);

        // R6: mid-frame write leaves current frame intact
        wait_frame();
        repeat (10) @(negedge clk);
        @(negedge clk);
        cfg_wr = 1'b1; cfg_frame_ratio = 10'(768); cfg_bit_ratio = 6'(16); cfg_master = 1'b1;
        @(negedge clk);
        cfg_wr = 1'b0;
        begin
            int n;
            n = 12;
            while (!frame_stb) begin @(negedge clk); n++; end
            check(n == 384, "R6 current frame unchanged", n, 384);
        end
        begin
            int n;
            n = 0;
            do begin @(negedge clk); n++; end while (!frame_stb && n < 2000);
            check(n == 768, "R6 next frame uses new ratio", n, 768);
        end

        // R7: frame strobe width
        wait_frame();
        @(negedge clk);
        check(frame_stb == 0, "R7 frame strobe single cycle", frame_stb, 0);

        // R9: direction control
        @(negedge clk); dir_wr = 1'b1; dir_is_input = 1'b1;
        @(negedge clk); dir_wr = 1'b0;
        check(mclk_oe == 0, "R9 direction input", mclk_oe, 0);
        @(negedge clk); dir_wr = 1'b1; dir_is_input = 1'b0;
        @(negedge clk); dir_wr = 1'b0;
        check(mclk_oe == 1, "R9 direction output", mclk_oe, 1);

        // R8: slave mode
        write_cfg(256, 32, 1'b0);
        check(bclk_oe == 0 && ws_oe == 0, "R8 enables off in slave", {bclk_oe, ws_oe}, 0);
        check(mclk_oe == 1, "R9 slave write keeps mclk_oe", mclk_oe, 1);
        ext_bclk = 1'b1; ext_ws = 1'b1;
        repeat (4) @(negedge clk);
        check(bclk_out == 1 && ws_out == 1, "R8 follows external high", {bclk_out, ws_out}, 3);
        ext_bclk = 1'b0;
        @(negedge clk);
        check(bclk_out == 1 && bit_fall_stb == 0, "R8 one cycle still old", {bclk_out, bit_fall_stb}, 2);
        @(negedge clk);
        check(bclk_out == 0 && bit_fall_stb == 1, "R8 fall after two cycles", {bclk_out, bit_fall_stb}, 1);
        @(negedge clk);
        check(bit_fall_stb == 0, "R8 fall strobe one cycle", bit_fall_stb, 0);
        ext_ws = 1'b0;
        @(negedge clk);
        check(frame_stb == 0, "R8 frame not yet", frame_stb, 0);
        @(negedge clk);
        check(frame_stb == 1 && ws_out == 0, "R8 frame on ws fall", {frame_stb, ws_out}, 2);
        @(negedge clk);
        check(frame_stb == 0, "R8 frame strobe one cycle", frame_stb, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule